// File: doc/BRIEF.md
# Set/Clear Pin Bank Controller

This block is a general-purpose pin controller that sits on a 32-bit word-addressed register bus. It runs four bidirectional ports (A, B, C and a six-pin port D), a bank of 23 input-only lines and a bank of 24 output-only lines. Software never writes an output level or a direction bit directly. Each such bit is changed through a pair of write-one-to-set and write-one-to-clear registers, so one bus write can change some pins without disturbing the others. A separate state register reports the current value. Inputs reach the bus through a two-flop synchroniser.

Port D does not follow the regular layout of the other ports. It has no direction registers of its own and uses the upper bits of port C's direction set/clear/state registers. Its output levels share a set/clear pair with the output-only bank. Its sampled inputs are spread across the same input word that also reports the input-only bank. Port C also has a 13-bit pin-function select register, which is held as set/clear state and driven out to the pad ring.

To drive a pin, software first writes the wanted level and then sets the direction bit. A pin therefore never drives a stale value.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset, every output level, direction, function-select and output-only bit is 0. All output-enable pins are low and a read returns 0.
- R2: A write to a set register drives to 1 each stored bit whose write-data bit is 1. Bits written as 0 keep their value. Word addresses for port A: set 17, clear 18, level state 19, direction set 20, direction clear 21, direction state 22, input 16. Port B uses the same layout at 24..30.
- R3: A write to a clear register drives to 0 each stored bit whose write-data bit is 1. Other bits keep their value.
- R4: A direction bit of 1 makes the pin an output: its output-enable pin is high. A bit of 0 makes it an input. Direction changes only through a bus write.
- R5: Port C and port D share the direction registers at word 4 (set), 5 (clear) and 6 (state). Bits 0..12 belong to port C pins 0..12. Bits 25..30 belong to port D pins 0..5.
- R6: The set/clear pair at words 1/2 controls port D levels in bits 25..30 and the output-only lines 0..23 in bits 0..23. Word 3 reads back both fields at those positions. Port C levels use set word 8 and clear word 9.
- R7: Input word 0 reports input-only lines 0..9 at bits 0..9, lines 10..18 at bits 15..23 and lines 19..22 at bits 25..28. It reports port D pins 0..4 at bits 10..14 and port D pin 5 at bit 24.
- R8: For ports A, B and C, pin n reads at bit n of the input word (words 16, 24 and 7). It reflects a pin change to any read strobe issued two or more cycles after the change.
- R9: Read data appears in the cycle after the read strobe and is 0 in every cycle that follows no read strobe.
- R10: Reads of unused bits, unused word addresses and the set/clear addresses return 0. Write-data bits with no storage behind them (bits 24 and 31 of words 1/2, bits above a port's width) change nothing.
- R11: Writes to input-word and state-word addresses change no stored state.
- R12: Port C's function select is set at word 10, cleared at word 11, read at word 12, and drives the function-select pins.
- R13: When the level is written before the direction, the pin's output value is already correct in the first cycle its output enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| pa_in_i | input | PA_W | Port A pin inputs |
| pa_out_o | output | PA_W | Port A output levels |
| pa_oe_o | output | PA_W | Port A output enables |
| pb_in_i | input | PB_W | Port B pin inputs |
| pb_out_o | output | PB_W | Port B output levels |
| pb_oe_o | output | PB_W | Port B output enables |
| pc_in_i | input | PC_W | Port C pin inputs |
| pc_out_o | output | PC_W | Port C output levels |
| pc_oe_o | output | PC_W | Port C output enables |
| pc_fsel_o | output | PC_W | Port C function-select bits |
| pd_in_i | input | 6 | Port D pin inputs |
| pd_out_o | output | 6 | Port D output levels |
| pd_oe_o | output | 6 | Port D output enables |
| inl_i | input | 23 | Input-only lines |
| outl_o | output | 24 | Output-only lines |

## Verification
Every stored bit drives a pin directly. A wrong set/clear update therefore shows on the level, enable or function-select pins on the clock edge of the write. A wrong bit placement in the shared words of port D shows only on a read, one cycle after the strobe. For that reason the bench checks each scattered field with patterns that put different values in neighbouring fields. A fault in the input synchroniser shows on the input words no later than three cycles after a pin change.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int BUS_W     = 32;
    localparam int PD_PINS   = 6;
    localparam int PD_LSB    = 25;   // port D level/direction bits 25..30
    localparam int OUTL_N    = 24;   // output-only lines at bits 0..23
    localparam int INL_N     = 23;   // input-only lines
    localparam int PD_IN_LSB = 10;   // port D pins 0..4 read at bits 10..14
    localparam int PD5_IN    = 24;   // port D pin 5 read at bit 24

    // shared word addresses
    localparam int A_PD_IN    = 0;
    localparam int A_PD_SET   = 1;
    localparam int A_PD_CLR   = 2;
    localparam int A_PD_ST    = 3;
    localparam int A_DIR_SET  = 4;
    localparam int A_DIR_CLR  = 5;
    localparam int A_DIR_ST   = 6;
    localparam int A_PC_IN    = 7;
    localparam int A_PC_SET   = 8;
    localparam int A_PC_CLR   = 9;
    localparam int A_FSEL_SET = 10;
    localparam int A_FSEL_CLR = 11;
    localparam int A_FSEL_ST  = 12;

    // regular ports: base word plus offset
    localparam int A_PA_BASE = 16;
    localparam int A_PB_BASE = 24;
    localparam int OF_IN     = 0;
    localparam int OF_SET    = 1;
    localparam int OF_CLR    = 2;
    localparam int OF_ST     = 3;
    localparam int OF_DSET   = 4;
    localparam int OF_DCLR   = 5;
    localparam int OF_DST    = 6;

    localparam logic [BUS_W-1:0] PD_WORD_MASK =
        ({BUS_W{1'b0}} | ((BUS_W'(1) << OUTL_N) - 1)) |
        (((BUS_W'(1) << PD_PINS) - 1) << PD_LSB);

    function automatic logic [BUS_W-1:0] dir_mask(input int pc_w);
        dir_mask = ((BUS_W'(1) << pc_w) - 1) |
                   (((BUS_W'(1) << PD_PINS) - 1) << PD_LSB);
    endfunction

    // port D input word: input-only lines in three runs, port D pins around them
    function automatic logic [BUS_W-1:0] pd_in_word(input logic [INL_N-1:0] inl,
                                                    input logic [PD_PINS-1:0] pins);
        logic [BUS_W-1:0] w;
        w        = '0;
        w[9:0]   = inl[9:0];
        w[14:10] = pins[4:0];
        w[23:15] = inl[18:10];
        w[PD5_IN] = pins[5];
        w[28:25] = inl[22:19];
        return w;
    endfunction

    typedef struct packed {
        logic [BUS_W-1:0] data;
    } rd_t;

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/pinbank_setclr.sv
module pinbank_setclr #(
    parameter int           W    = 8,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_i,
    input  logic         clr_i,
    input  logic [W-1:0] bits_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] val;
    } sc_t;

    sc_t          sc_d, sc_q;
    logic [W-1:0] eff;

    always_comb begin
        eff  = bits_i & MASK;
        sc_d = sc_q;
        if (set_i) sc_d.val = sc_d.val | eff;
        if (clr_i) sc_d.val = sc_d.val & ~eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sc_q <= '0;
        else        sc_q <= sc_d;
    end

    assign q_o = sc_q.val;
endmodule

// File: rtl/pinbank_port.sv
module pinbank_port
    import pinbank_pkg::*;
#(
    parameter int W      = 8,
    parameter int ADDR_W = 5,
    parameter int BASE   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [W-1:0]      wdata_i,
    input  logic [W-1:0]      pin_i,
    output logic [W-1:0]      out_o,
    output logic [W-1:0]      oe_o,
    output logic [BUS_W-1:0]  rd_o
);
    localparam logic [ADDR_W-1:0] AW_IN   = ADDR_W'(BASE + OF_IN);
    localparam logic [ADDR_W-1:0] AW_SET  = ADDR_W'(BASE + OF_SET);
    localparam logic [ADDR_W-1:0] AW_CLR  = ADDR_W'(BASE + OF_CLR);
    localparam logic [ADDR_W-1:0] AW_ST   = ADDR_W'(BASE + OF_ST);
    localparam logic [ADDR_W-1:0] AW_DSET = ADDR_W'(BASE + OF_DSET);
    localparam logic [ADDR_W-1:0] AW_DCLR = ADDR_W'(BASE + OF_DCLR);
    localparam logic [ADDR_W-1:0] AW_DST  = ADDR_W'(BASE + OF_DST);

    logic         lv_set, lv_clr, dr_set, dr_clr;
    logic [W-1:0] in_s;

    always_comb begin
        lv_set = wr_i && (addr_i == AW_SET);
        lv_clr = wr_i && (addr_i == AW_CLR);
        dr_set = wr_i && (addr_i == AW_DSET);
        dr_clr = wr_i && (addr_i == AW_DCLR);
    end

    pinbank_sync #(.W(W)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(in_s)
    );

    pinbank_setclr #(.W(W)) u_lvl (
        .clk(clk), .rst_n(rst_n), .set_i(lv_set), .clr_i(lv_clr),
        .bits_i(wdata_i), .q_o(out_o)
    );

    pinbank_setclr #(.W(W)) u_dir (
        .clk(clk), .rst_n(rst_n), .set_i(dr_set), .clr_i(dr_clr),
        .bits_i(wdata_i), .q_o(oe_o)
    );

    always_comb begin
        rd_o = '0;
        if (addr_i == AW_IN)       rd_o[W-1:0] = in_s;
        else if (addr_i == AW_ST)  rd_o[W-1:0] = out_o;
        else if (addr_i == AW_DST) rd_o[W-1:0] = oe_o;
    end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int PA_W   = 8,
    parameter int PB_W   = 24,
    parameter int PC_W   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [PA_W-1:0]   pa_in_i,
    output logic [PA_W-1:0]   pa_out_o,
    output logic [PA_W-1:0]   pa_oe_o,
    input  logic [PB_W-1:0]   pb_in_i,
    output logic [PB_W-1:0]   pb_out_o,
    output logic [PB_W-1:0]   pb_oe_o,
    input  logic [PC_W-1:0]   pc_in_i,
    output logic [PC_W-1:0]   pc_out_o,
    output logic [PC_W-1:0]   pc_oe_o,
    output logic [PC_W-1:0]   pc_fsel_o,
    input  logic [5:0]        pd_in_i,
    output logic [5:0]        pd_out_o,
    output logic [5:0]        pd_oe_o,
    input  logic [22:0]       inl_i,
    output logic [23:0]       outl_o
);
    localparam int                 N_REG    = 2;
    localparam logic [BUS_W-1:0]   DIR_MASK = dir_mask(PC_W);

    // ---------------- regular ports A and B ----------------
    logic [N_REG-1:0][BUS_W-1:0] reg_rd;

    generate
        for (genvar g = 0; g < N_REG; g++) begin : g_port
            if (g == 0) begin : g_a
                pinbank_port #(.W(PA_W), .ADDR_W(ADDR_W), .BASE(A_PA_BASE)) u_port (
                    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
                    .wdata_i(bus_wdata[PA_W-1:0]), .pin_i(pa_in_i),
                    .out_o(pa_out_o), .oe_o(pa_oe_o), .rd_o(reg_rd[g])
                );
            end else begin : g_b
                pinbank_port #(.W(PB_W), .ADDR_W(ADDR_W), .BASE(A_PB_BASE)) u_port (
                    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
                    .wdata_i(bus_wdata[PB_W-1:0]), .pin_i(pb_in_i),
                    .out_o(pb_out_o), .oe_o(pb_oe_o), .rd_o(reg_rd[g])
                );
            end
        end
    endgenerate

    // ---------------- irregular ports C and D ----------------
    logic pc_set, pc_clr, fs_set, fs_clr, dr_set, dr_clr, pd_set, pd_clr;

    always_comb begin
        pc_set = bus_wr && (bus_addr == ADDR_W'(A_PC_SET));
        pc_clr = bus_wr && (bus_addr == ADDR_W'(A_PC_CLR));
        fs_set = bus_wr && (bus_addr == ADDR_W'(A_FSEL_SET));
        fs_clr = bus_wr && (bus_addr == ADDR_W'(A_FSEL_CLR));
        dr_set = bus_wr && (bus_addr == ADDR_W'(A_DIR_SET));
        dr_clr = bus_wr && (bus_addr == ADDR_W'(A_DIR_CLR));
        pd_set = bus_wr && (bus_addr == ADDR_W'(A_PD_SET));
        pd_clr = bus_wr && (bus_addr == ADDR_W'(A_PD_CLR));
    end

    logic [PC_W-1:0]    pc_in_s;
    logic [5:0]         pd_in_s;
    logic [22:0]        inl_s;
    logic [BUS_W-1:0]   dir_q;
    logic [BUS_W-1:0]   pdw_q;

    pinbank_sync #(.W(PC_W)) u_sync_pc (
        .clk(clk), .rst_n(rst_n), .d_i(pc_in_i), .q_o(pc_in_s)
    );
    pinbank_sync #(.W(PD_PINS)) u_sync_pd (
        .clk(clk), .rst_n(rst_n), .d_i(pd_in_i), .q_o(pd_in_s)
    );
    pinbank_sync #(.W(INL_N)) u_sync_inl (
        .clk(clk), .rst_n(rst_n), .d_i(inl_i), .q_o(inl_s)
    );

    pinbank_setclr #(.W(PC_W)) u_pc_lvl (
        .clk(clk), .rst_n(rst_n), .set_i(pc_set), .clr_i(pc_clr),
        .bits_i(bus_wdata[PC_W-1:0]), .q_o(pc_out_o)
    );
    pinbank_setclr #(.W(PC_W)) u_pc_fsel (
        .clk(clk), .rst_n(rst_n), .set_i(fs_set), .clr_i(fs_clr),
        .bits_i(bus_wdata[PC_W-1:0]), .q_o(pc_fsel_o)
    );
    pinbank_setclr #(.W(BUS_W), .MASK(DIR_MASK)) u_dir_shared (
        .clk(clk), .rst_n(rst_n), .set_i(dr_set), .clr_i(dr_clr),
        .bits_i(bus_wdata), .q_o(dir_q)
    );
    pinbank_setclr #(.W(BUS_W), .MASK(PD_WORD_MASK)) u_pd_word (
        .clk(clk), .rst_n(rst_n), .set_i(pd_set), .clr_i(pd_clr),
        .bits_i(bus_wdata), .q_o(pdw_q)
    );

    assign pc_oe_o  = dir_q[PC_W-1:0];
    assign pd_oe_o  = dir_q[PD_LSB +: PD_PINS];
    assign pd_out_o = pdw_q[PD_LSB +: PD_PINS];
    assign outl_o   = pdw_q[OUTL_N-1:0];

    // ---------------- read path ----------------
    rd_t              rd_d, rd_q;
    logic [BUS_W-1:0] loc_rd;

    always_comb begin
        loc_rd = '0;
        case (bus_addr)
            ADDR_W'(A_PD_IN):   loc_rd = pd_in_word(inl_s, pd_in_s);
            ADDR_W'(A_PD_ST):   loc_rd = pdw_q;
            ADDR_W'(A_DIR_ST):  loc_rd = dir_q;
            ADDR_W'(A_PC_IN):   loc_rd[PC_W-1:0] = pc_in_s;
            ADDR_W'(A_FSEL_ST): loc_rd[PC_W-1:0] = pc_fsel_o;
            default:            loc_rd = '0;
        endcase

        rd_d = '0;
        if (bus_rd) rd_d.data = loc_rd | reg_rd[0] | reg_rd[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.data;
endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk
    import pinbank_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int PA_W   = 8,
    parameter int PC_W   = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [PA_W-1:0]   pa_out_o,
    input logic [PA_W-1:0]   pa_oe_o,
    input logic [PC_W-1:0]   pc_oe_o,
    input logic [PC_W-1:0]   pc_fsel_o,
    input logic [5:0]        pd_oe_o
);
    // R9
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == 32'h0));

    // R2
    pa_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_PA_BASE + OF_SET)) |=>
        ((pa_out_o & $past(bus_wdata[PA_W-1:0])) == $past(bus_wdata[PA_W-1:0])));

    // R3
    pa_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_PA_BASE + OF_CLR)) |=>
        ((pa_out_o & $past(bus_wdata[PA_W-1:0])) == '0));

    // R5
    pd_dir_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_DIR_SET)) |=>
        ((pd_oe_o & $past(bus_wdata[30:25])) == $past(bus_wdata[30:25])));

    // R4
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(pa_oe_o) && $stable(pc_oe_o) && $stable(pd_oe_o)));

    // R11
    state_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADDR_W'(A_PA_BASE + OF_DST) ||
                    bus_addr == ADDR_W'(A_DIR_ST))) |=>
        ($stable(pa_oe_o) && $stable(pa_out_o) && $stable(pc_oe_o)));

    // R12
    fsel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_FSEL_SET)) |=>
        ((pc_fsel_o & $past(bus_wdata[PC_W-1:0])) == $past(bus_wdata[PC_W-1:0])));
endmodule

bind pinbank_ctrl pinbank_chk #(.ADDR_W(ADDR_W), .PA_W(PA_W), .PC_W(PC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_out_o(pa_out_o), .pa_oe_o(pa_oe_o), .pc_oe_o(pc_oe_o),
    .pc_fsel_o(pc_fsel_o), .pd_oe_o(pd_oe_o)
);

// File: tb/pinbank_ctrl_bench.sv
module pinbank_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [7:0]  pa_in = '0, pa_out, pa_oe;
    logic [23:0] pb_in = '0, pb_out, pb_oe;
    logic [12:0] pc_in = '0, pc_out, pc_oe, pc_fsel;
    logic [5:0]  pd_in = '0, pd_out, pd_oe;
    logic [22:0] inl = '0;
    logic [23:0] outl;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pinbank_ctrl u_pinbank_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pa_in_i(pa_in), .pa_out_o(pa_out), .pa_oe_o(pa_oe),
        .pb_in_i(pb_in), .pb_out_o(pb_out), .pb_oe_o(pb_oe),
        .pc_in_i(pc_in), .pc_out_o(pc_out), .pc_oe_o(pc_oe), .pc_fsel_o(pc_fsel),
        .pd_in_i(pd_in), .pd_out_o(pd_out), .pd_oe_o(pd_oe),
        .inl_i(inl), .outl_o(outl)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 5'(a);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] exp_pd_word(input logic [22:0] l, input logic [5:0] p);
        logic [31:0] w = '0;
        for (int i = 0; i < 10; i++) w[i] = l[i];
        for (int i = 0; i < 5; i++)  w[10 + i] = p[i];
        for (int i = 0; i < 9; i++)  w[15 + i] = l[10 + i];
        w[24] = p[5];
        for (int i = 0; i < 4; i++)  w[25 + i] = l[19 + i];
        return w;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 pa_out", 32'(pa_out), 0);
        chk("R1 pa_oe", 32'(pa_oe), 0);
        chk("R1 pb_oe", 32'(pb_oe), 0);
        chk("R1 pc_oe/fsel", 32'({pc_oe, pc_fsel}), 0);
        chk("R1 pd/outl", 32'({pd_out, pd_oe, outl}), 0);
        chk("R1 rdata", bus_rdata, 0);
        rd(6, d);  chk("R1 dir state", d, 0);
        rd(22, d); chk("R1 pa dir state", d, 0);
    endtask

    task automatic t_port_a();
        logic [31:0] d;
        wr(17, 32'hA5);       chk("R2 pa set", 32'(pa_out), 32'hA5);
        wr(17, 32'h0F);       chk("R2 pa set keeps", 32'(pa_out), 32'hAF);
        wr(18, 32'h81);       chk("R3 pa clr", 32'(pa_out), 32'h2E);
        wr(17, 32'hFFFFFF00); chk("R10 pa wide set", 32'(pa_out), 32'h2E);
        rd(19, d);            chk("R2 pa level state", d, 32'h2E);
        chk("R9 rdata idle", bus_rdata, 32'h2E);
        @(negedge clk);       chk("R9 rdata zero after", bus_rdata, 0);
        wr(20, 32'h3C);       chk("R4 pa oe", 32'(pa_oe), 32'h3C);
        wr(21, 32'h04);       chk("R4 pa oe clr", 32'(pa_oe), 32'h38);
        rd(22, d);            chk("R4 pa dir state", d, 32'h38);
    endtask

    task automatic t_port_b();
        logic [31:0] d;
        wr(25, 32'h00F0F0F1);
        wr(26, 32'h000000F1); chk("R3 pb clr", 32'(pb_out), 32'h00F0F000);
        rd(27, d);            chk("R2 pb level state", d, 32'h00F0F000);
        wr(28, 32'h00800001); rd(30, d); chk("R4 pb dir state", d, 32'h00800001);
        chk("R4 pb oe", 32'(pb_oe), 32'h00800001);
    endtask

    task automatic t_port_c();
        logic [31:0] d;
        wr(8, 32'h1FFF);      wr(9, 32'h1000);
        chk("R6 pc level", 32'(pc_out), 32'h0FFF);
        wr(4, 32'h7E001001);
        chk("R5 pc oe", 32'(pc_oe), 32'h1001);
        chk("R5 pd oe", 32'(pd_oe), 32'h3F);
        wr(5, 32'h02000001);
        chk("R5 pd oe clr", 32'(pd_oe), 32'h3E);
        rd(6, d);             chk("R5 shared dir state", d, 32'h7C001000);
        wr(10, 32'h1234);     wr(11, 32'h0030);
        chk("R12 fsel pins", 32'(pc_fsel), 32'h1204);
        rd(12, d);            chk("R12 fsel state", d, 32'h1204);
    endtask

    task automatic t_port_d();
        logic [31:0] d;
        wr(1, 32'h7E000001);
        chk("R6 pd level", 32'(pd_out), 32'h3F);
        wr(1, 32'h00ABCDEF);  chk("R6 outl", 32'(outl), 32'hABCDEF);
        wr(2, 32'h40000F00);
        chk("R6 pd clr", 32'(pd_out), 32'h1F);
        chk("R6 outl clr", 32'(outl), 32'hABC0EF);
        wr(1, 32'h81000000);
        rd(3, d);             chk("R10 unused bits 24/31", d, 32'h3EABC0EF);
    endtask

    task automatic t_inputs();
        logic [31:0] d;
        pa_in = 8'h5A; pb_in = 24'hC3A5F0; pc_in = 13'h1ABC;
        pd_in = 6'b100101; inl = 23'h5A5A5A;
        repeat (3) @(negedge clk);
        rd(16, d); chk("R8 pa in", d, 32'h5A);
        rd(24, d); chk("R8 pb in", d, 32'hC3A5F0);
        rd(7, d);  chk("R8 pc in", d, 32'h1ABC);
        rd(0, d);  chk("R7 pd word a", d, exp_pd_word(23'h5A5A5A, 6'b100101));
        pd_in = 6'b011010; inl = 23'h2A5F03;
        repeat (3) @(negedge clk);
        rd(0, d);  chk("R7 pd word b", d, exp_pd_word(23'h2A5F03, 6'b011010));
        pd_in = 6'b100000; inl = '0;
        repeat (3) @(negedge clk);
        rd(0, d);  chk("R7 pin5 at bit 24", d, 32'h01000000);
        pd_in = 6'b000001;
        repeat (3) @(negedge clk);
        rd(0, d);  chk("R7 pin0 at bit 10", d, 32'h00000400);
    endtask

    task automatic t_unused();
        logic [31:0] d;
        rd(13, d); chk("R10 hole 13", d, 0);
        rd(15, d); chk("R10 hole 15", d, 0);
        rd(23, d); chk("R10 hole 23", d, 0);
        rd(31, d); chk("R10 hole 31", d, 0);
        rd(1, d);  chk("R10 set word reads 0", d, 0);
        rd(4, d);  chk("R10 dir set reads 0", d, 0);
        rd(18, d); chk("R10 clr word reads 0", d, 0);
    endtask

    task automatic t_order();
        wr(17, 32'h40);
        chk("R13 level before oe", 32'({pa_out[6], pa_oe[6]}), 32'b10);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'd20; bus_wdata = 32'h40;
        @(posedge clk); #1;
        chk("R13 first driven cycle", 32'({pa_out[6], pa_oe[6]}), 32'b11);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic t_state_writes();
        logic [31:0] d;
        wr(19, 32'hFF); wr(22, 32'hFF); wr(3, 32'hFFFFFFFF);
        wr(6, 32'hFFFFFFFF); wr(12, 32'h1FFF); wr(0, 32'hFFFFFFFF);
        chk("R11 pa unchanged", 32'({pa_out, pa_oe}), 32'h6E78);
        chk("R11 pc oe unchanged", 32'(pc_oe), 32'h1000);
        chk("R11 fsel unchanged", 32'(pc_fsel), 32'h1204);
        rd(3, d); chk("R11 pd word unchanged", d, 32'h3EABC0EF);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_port_a();
        t_port_b();
        t_port_c();
        t_port_d();
        t_inputs();
        t_unused();
        t_order();
        t_state_writes();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule